// File: doc/BRIEF.md
# Early receive interrupt trigger

This block follows a receive frame while its bytes are copied into host memory. At some point during the frame it raises a one-cycle early interrupt, so that software can start work on the frame before the whole frame has arrived. The trigger point is chosen separately for each frame.

A header-valid strobe tells the block whether the frame's protocol was recognised and gives the frame length read from that protocol's header. The trigger point is then one of two values:
- for a recognised frame, a fraction n/16 of that length;
- a fixed byte count taken from a 12-bit setting.

A force input makes every frame use the fixed count. Frames that were not recognised always use the fixed count. A frame-start pulse opens each frame, and a frame-end pulse closes it.

The threshold select, the force bit and the byte-count setting are live inputs that are read on every cycle. The protocol flag and the length are captured once per frame.

Top module: `early_rx_trigger`

## Requirements
- R1: After reset, `early_irq` is 0.
- R2: The fraction rule applies when `force_count` is 0 and the frame was flagged as recognised. With `frac_sel` = n (n from 1 to 15) and a captured length L, the target is T = (L*n)>>4. `early_irq` is high for the one cycle after the clock edge that samples the counted byte strobe that brings the byte count to at least T. If T is 0, the first counted byte triggers.
- R3: If the fraction rule applies and `frac_sel` is 0, no early interrupt is issued for the frame, whatever `byte_limit` holds.
- R4: If `force_count` is 1, the target is `byte_limit`, whether or not the frame was recognised. The pulse comes after the byte that brings the count to at least that value.
- R5: If `force_count` is 0 and the frame was flagged as not recognised, the target is `byte_limit`.
- R6: If the count rule applies and `byte_limit` is 0, no early interrupt is issued.
- R7: At most one early interrupt is issued per frame, and each one lasts exactly one cycle.
- R8: `frame_start` clears the byte count, the fired state and the captured header. A byte strobe in the same cycle as `frame_start` is not counted.
- R9: After `frame_end`, no byte is counted and no early interrupt is issued until the next `frame_start`. A frame that ends before its target is reached produces no pulse.
- R10: The protocol flag and the length are captured only on the first `hdr_valid` of a frame. Later `hdr_valid` strobes in the same frame are ignored. Until the header is captured, the frame is treated as not recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frac_sel | input | 4 | Sixteenths multiplier n for recognised frames; 0 turns the fraction trigger off |
| force_count | input | 1 | 1: every frame uses `byte_limit` |
| byte_limit | input | 12 | Fixed byte-count trigger point; 0 turns the count trigger off |
| hdr_valid | input | 1 | Strobe: `proto_known` and `frame_len` are valid |
| proto_known | input | 1 | The frame's protocol was recognised |
| frame_len | input | 16 | Total frame length in bytes, taken from the header |
| frame_start | input | 1 | Pulse that opens a new frame |
| frame_end | input | 1 | Pulse that closes the current frame |
| byte_xfer | input | 1 | One byte moved to the host buffer this cycle |
| early_irq | output | 1 | One-cycle early interrupt pulse |

## Verification
The bound checker watches the following on every cycle:
- every pulse lasts one cycle and follows a byte strobe that did not coincide with a frame start;
- no pulse occurs while the frame is closed or after the frame has already fired;
- no pulse occurs when the rule that applies has a zero setting.

The byte on which the pulse lands is checked only by the bench's scenarios. These cover the fraction arithmetic including rounding to a zero target, the choice between the two rules under the force bit and the recognised flag, a second header strobe being ignored, and a byte that arrives together with the frame start being left uncounted.

// File: rtl/early_rx_trigger.sv
module early_rx_trigger #(
  parameter int LEN_W  = 16,
  parameter int LIM_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] frac_sel,
  input  logic              force_count,
  input  logic [LIM_W-1:0]  byte_limit,
  input  logic              hdr_valid,
  input  logic              proto_known,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              byte_xfer,
  output logic              early_irq
);
  localparam int PROD_W = LEN_W + FRAC_W;

  logic             active, fired, hdr_seen, known_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic [PROD_W-1:0] prod;
  logic [LEN_W-1:0] frac_pt, target, cnt_inc;
  logic             use_frac, enabled, counted, hit;

  assign prod     = len_q * frac_sel;
  assign frac_pt  = prod[PROD_W-1:FRAC_W];
  assign use_frac = !force_count && known_q;
  assign target   = use_frac ? frac_pt : LEN_W'(byte_limit);
  assign enabled  = use_frac ? (frac_sel != '0) : (byte_limit != '0);
  assign counted  = active && byte_xfer && !frame_start;
  assign cnt_inc  = (cnt == '1) ? cnt : cnt + 1'b1;
  assign hit      = counted && !fired && enabled && (cnt_inc >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      fired     <= 1'b0;
      hdr_seen  <= 1'b0;
      known_q   <= 1'b0;
      len_q     <= '0;
      cnt       <= '0;
      early_irq <= 1'b0;
    end else if (frame_start) begin
      active    <= 1'b1;
      fired     <= 1'b0;
      hdr_seen  <= 1'b0;
      known_q   <= 1'b0;
      len_q     <= '0;
      cnt       <= '0;
      early_irq <= 1'b0;
    end else begin
      early_irq <= hit;
      if (hit) fired <= 1'b1;
      if (counted) cnt <= cnt_inc;
      if (active && hdr_valid && !hdr_seen) begin
        hdr_seen <= 1'b1;
        known_q  <= proto_known;
        len_q    <= frame_len;
      end
      if (frame_end) active <= 1'b0;
    end
  end
endmodule

module early_rx_trigger_chk #(
  parameter int LIM_W  = 12,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              early_irq,
  input logic              byte_xfer,
  input logic              frame_start,
  input logic              force_count,
  input logic [LIM_W-1:0]  byte_limit,
  input logic [FRAC_W-1:0] frac_sel,
  input logic              known_q,
  input logic              active,
  input logic              fired
);
  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !early_irq);

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    early_irq |=> !early_irq);

  p_once_per_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !frame_start) |=> !early_irq);

  p_follows_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_irq) |-> ($past(byte_xfer) && !$past(frame_start)));

  p_frac_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_count && known_q && frac_sel == '0) |=> !early_irq);

  p_limit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_count || !known_q) && byte_limit == '0) |=> !early_irq);

  p_closed_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !frame_start) |=> !early_irq);
endmodule

bind early_rx_trigger early_rx_trigger_chk #(.LIM_W(LIM_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .early_irq(early_irq), .byte_xfer(byte_xfer),
  .frame_start(frame_start), .force_count(force_count), .byte_limit(byte_limit),
  .frac_sel(frac_sel), .known_q(known_q), .active(active), .fired(fired)
);

// File: tb/early_rx_trigger_test.sv
module early_rx_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  frac_sel = '0;
  logic        force_count = 1'b0;
  logic [11:0] byte_limit = '0;
  logic        hdr_valid = 1'b0, proto_known = 1'b0;
  logic [15:0] frame_len = '0;
  logic        frame_start = 1'b0, frame_end = 1'b0, byte_xfer = 1'b0;
  logic        early_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  early_rx_trigger uut (
    .clk(clk), .rst_n(rst_n), .frac_sel(frac_sel), .force_count(force_count),
    .byte_limit(byte_limit), .hdr_valid(hdr_valid), .proto_known(proto_known),
    .frame_len(frame_len), .frame_start(frame_start), .frame_end(frame_end),
    .byte_xfer(byte_xfer), .early_irq(early_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit frc, input int n, input int lim);
    force_count = frc;
    frac_sel    = 4'(n);
    byte_limit  = 12'(lim);
  endtask

  task automatic run_frame(input bit kn, input int len, input int nb, input int end_at,
                           input bit second_hdr, input bit byte_on_start,
                           input int exp_at, input string req);
    int pulses = 0;
    int at = 0;
    frame_start = 1'b1;
    byte_xfer   = byte_on_start;
    @(negedge clk);
    frame_start = 1'b0;
    byte_xfer   = 1'b0;
    hdr_valid   = 1'b1;
    proto_known = kn;
    frame_len   = 16'(len);
    @(negedge clk);
    if (second_hdr) begin
      proto_known = !kn;
      frame_len   = 16'd16;
      @(negedge clk);
    end
    hdr_valid = 1'b0;
    for (int i = 1; i <= nb; i++) begin
      byte_xfer = 1'b1;
      frame_end = (i == end_at);
      @(negedge clk);
      if (early_irq) begin
        pulses++;
        if (at == 0) at = i;
      end
    end
    byte_xfer = 1'b0;
    frame_end = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (early_irq) pulses++;
    end
    check(pulses == (exp_at != 0 ? 1 : 0), {req, " pulse count"}, pulses, exp_at != 0 ? 1 : 0);
    check(at == exp_at, {req, " trigger byte"}, at, exp_at);
  endtask

  task automatic t_reset;
    check(early_irq == 1'b0, "R1 reset", int'(early_irq), 0);
  endtask

  task automatic t_fraction;
    setup(0, 5, 3);   run_frame(1, 100, 40, 0, 0, 0, 31, "R2 5/16 of 100");
    setup(0, 15, 3);  run_frame(1, 64, 70, 0, 0, 0, 60, "R2 15/16 of 64");
    setup(0, 1, 3);   run_frame(1, 10, 5, 0, 0, 0, 1, "R2 zero target");
  endtask

  task automatic t_frac_off;
    setup(0, 0, 20);  run_frame(1, 100, 40, 0, 0, 0, 0, "R3 n=0");
  endtask

  task automatic t_forced;
    setup(1, 8, 12);  run_frame(1, 100, 30, 0, 0, 0, 12, "R4 forced known");
    setup(1, 8, 9);   run_frame(0, 100, 30, 0, 0, 0, 9, "R4 forced unknown");
  endtask

  task automatic t_unknown;
    setup(0, 8, 7);   run_frame(0, 200, 30, 0, 0, 0, 7, "R5 unknown limit");
  endtask

  task automatic t_limit_off;
    setup(0, 8, 0);   run_frame(0, 200, 30, 0, 0, 0, 0, "R6 limit 0");
    setup(1, 8, 0);   run_frame(1, 200, 30, 0, 0, 0, 0, "R6 forced limit 0");
  endtask

  task automatic t_once;
    setup(1, 0, 2);   run_frame(0, 0, 50, 0, 0, 0, 2, "R7 single pulse");
  endtask

  task automatic t_start_byte;
    setup(0, 0, 3);   run_frame(0, 0, 10, 0, 0, 1, 3, "R8 byte at start");
  endtask

  task automatic t_early_end;
    setup(0, 0, 10);  run_frame(0, 0, 20, 5, 0, 0, 0, "R9 ended early");
    setup(0, 0, 4);   run_frame(0, 0, 10, 0, 0, 0, 4, "R9 next frame reopens");
  endtask

  task automatic t_header_once;
    setup(0, 4, 5);   run_frame(1, 160, 50, 0, 1, 0, 40, "R10 second header ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fraction;
    t_frac_off;
    t_forced;
    t_unknown;
    t_limit_off;
    t_once;
    t_start_byte;
    t_early_end;
    t_header_once;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule